// File: doc/BRIEF.md
# Fixed-Rank Maskable Interrupt Controller

This block gathers interrupt requests from sixteen device slots and presents one interrupt line to a processor. Each slot has its own block bit in a mask register. A single mask write replaces every bit at once from one 16-bit data word. A slot's rank comes only from its index, and slot 0 ranks highest. Software decides which slots may interrupt, but it cannot reorder them.

When the processor acknowledges, the block latches the device code of the highest-ranked unblocked requester and drops its global interrupt enable. Each slot's device code is its index plus a configurable base, in a 6-bit code space. Service code then reads that code and branches to the matching handler. Nesting works as follows. On entry, software writes a mask that blocks its own slot and every lower-ranked slot, then strobes end-of-service to re-arm the global enable. From then on, only a higher-ranked device can break in. When that nested handler finishes, it restores the earlier mask, and the lower-ranked service resumes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every mask bit is 0 (all slots unblocked), the global enable is set and `ackCode` reads 0.
- R2: `intReq` is 1 exactly when the global enable is set and at least one slot with its mask bit at 0 has its `devReq` bit at 1; it follows `devReq` combinationally.
- R3: A mask bit at 1 blocks the slot of the same index: that slot's request alone never raises `intReq` and is never chosen at acknowledge.
- R4: A cycle with `maskWe` high loads all sixteen mask bits from `maskData` at that clock edge (bit i controls slot i), and the new mask acts from the following cycle.
- R5: At an `intAck` edge the block latches the code of the lowest-indexed unblocked requester into `ackCode`, readable from the next cycle; slot i's code is `CODE_BASE + i` (8 + i by default).
- R6: An `intAck` edge clears the global enable, so `intReq` stays 0 afterwards whatever the requests.
- R7: An `intAck` with no unblocked request pending latches code 0.
- R8: An `svcEnd` edge sets the global enable; if `intAck` and `svcEnd` are high in the same cycle, the acknowledge wins and the enable ends up clear.
- R9: With lower-ranked slots blocked during a service, a request from a higher-ranked slot raises `intReq` and is the one acknowledged; restoring the mask lets the blocked lower request be served again.
- R10: `ackCode` holds its value in every cycle without `intAck`, even when requests or the mask change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| devReq | input | 16 | Per-slot request lines, bit i from slot i |
| maskWe | input | 1 | Load the mask register from `maskData` |
| maskData | input | 16 | New mask word, 1 blocks the slot |
| intAck | input | 1 | Acknowledge: latch winner code, clear global enable |
| svcEnd | input | 1 | End-of-service strobe: set global enable |
| intReq | output | 1 | Interrupt request to the processor |
| ackCode | output | 6 | Code of the slot latched at the last acknowledge |

## Verification
The bench puts several requests up together and checks that the lowest index wins. A reversed priority scan would return the code of the lowest-ranked slot instead. It writes complementary mask words and probes slots on both sides of the boundary, which catches a mask that loads only part of the word or uses the inverted polarity. It also runs an acknowledge with every request blocked, which must return 0 and not a stale code or slot 0's code. It drives acknowledge and end-of-service in the same cycle, and a design with the wrong precedence would leave the interrupt line armed. A two-level nesting run checks that a blocked lower-ranked request stays silent while a higher one breaks in, and that it is served again once the mask is restored.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic loadMask;     // replace the whole mask register
    logic captureCode;  // latch the current winner's code
  } irqStrobes_t;

endpackage

// File: rtl/prio_irq_datapath.sv
module prio_irq_datapath
  import prio_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int CODE_W    = 6,
  parameter int CODE_BASE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  irqStrobes_t          strobes,
  input  logic [NUM_SLOTS-1:0] devReq,
  input  logic [NUM_SLOTS-1:0] maskData,
  output logic                 anyPending,
  output logic [NUM_SLOTS-1:0] maskQ,
  output logic [CODE_W-1:0]    ackCode
);

  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [NUM_SLOTS-1:0] liveReq;
  logic [CODE_W-1:0]    slotCode [NUM_SLOTS];
  logic [IDX_W-1:0]     winIdx;
  logic                 winFound;
  logic [CODE_W-1:0]    winCode;

  // Each slot's code is fixed by its index.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_code
    assign slotCode[g] = CODE_W'(CODE_BASE + g);
  end

  // A set mask bit blocks the slot.
  assign liveReq    = devReq & ~maskQ;
  assign anyPending = |liveReq;

  // Scan from the lowest rank upwards so that the lowest index wins.
  always_comb begin
    winIdx   = '0;
    winFound = 1'b0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (liveReq[i]) begin
        winIdx   = IDX_W'(i);
        winFound = 1'b1;
      end
    end
    winCode = winFound ? slotCode[winIdx] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      maskQ   <= '0;
      ackCode <= '0;
    end else begin
      if (strobes.loadMask)    maskQ   <= maskData;
      if (strobes.captureCode) ackCode <= winCode;
    end
  end

endmodule

// File: rtl/prio_irq_control.sv
module prio_irq_control
  import prio_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        maskWe,
  input  logic        intAck,
  input  logic        svcEnd,
  input  logic        anyPending,
  output irqStrobes_t strobes,
  output logic        gieQ,
  output logic        intReq
);

  always_comb begin
    strobes.loadMask    = maskWe;
    strobes.captureCode = intAck;
  end

  // The global enable drops on acknowledge and rises on end of service.
  // Acknowledge takes precedence.
  always_ff @(posedge clk) begin
    if (!rst_n)      gieQ <= 1'b1;
    else if (intAck) gieQ <= 1'b0;
    else if (svcEnd) gieQ <= 1'b1;
  end

  assign intReq = anyPending & gieQ;

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int CODE_W    = 6,
  parameter int CODE_BASE = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] devReq,
  input  logic                 maskWe,
  input  logic [NUM_SLOTS-1:0] maskData,
  input  logic                 intAck,
  input  logic                 svcEnd,
  output logic                 intReq,
  output logic [CODE_W-1:0]    ackCode
);

  irqStrobes_t          strobes;
  logic                 anyPending;
  logic                 gieQ;
  logic [NUM_SLOTS-1:0] maskQ;

  prio_irq_control u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .maskWe     (maskWe),
    .intAck     (intAck),
    .svcEnd     (svcEnd),
    .anyPending (anyPending),
    .strobes    (strobes),
    .gieQ       (gieQ),
    .intReq     (intReq)
  );

  prio_irq_datapath #(
    .NUM_SLOTS (NUM_SLOTS),
    .CODE_W    (CODE_W),
    .CODE_BASE (CODE_BASE)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .devReq     (devReq),
    .maskData   (maskData),
    .anyPending (anyPending),
    .maskQ      (maskQ),
    .ackCode    (ackCode)
  );

endmodule

// File: rtl/prio_irq_checker.sv
module prio_irq_checker #(
  parameter int NUM_SLOTS = 16,
  parameter int CODE_W    = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] devReq,
  input logic                 maskWe,
  input logic [NUM_SLOTS-1:0] maskData,
  input logic                 intAck,
  input logic                 svcEnd,
  input logic                 intReq,
  input logic [CODE_W-1:0]    ackCode,
  input logic [NUM_SLOTS-1:0] maskQ,
  input logic                 gieQ
);

  assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    maskWe |=> maskQ == $past(maskData));

  assert_blocked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    intReq |-> (devReq & ~maskQ) != '0);

  assert_ack_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    intAck |=> !intReq);

  assert_empty_ack_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (intAck && (devReq & ~maskQ) == '0) |=> ackCode == '0);

  assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (svcEnd && !intAck) |=> gieQ);

  assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !intAck |=> $stable(ackCode));

endmodule

bind prio_irq_ctrl prio_irq_checker #(
  .NUM_SLOTS (NUM_SLOTS),
  .CODE_W    (CODE_W)
) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .devReq   (devReq),
  .maskWe   (maskWe),
  .maskData (maskData),
  .intAck   (intAck),
  .svcEnd   (svcEnd),
  .intReq   (intReq),
  .ackCode  (ackCode),
  .maskQ    (maskQ),
  .gieQ     (gieQ)
);

// File: tb/prio_irq_ctrl_test.sv
`timescale 1ns/1ps
module prio_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] devReq = '0;
  logic        maskWe = 1'b0;
  logic [15:0] maskData = '0;
  logic        intAck = 1'b0;
  logic        svcEnd = 1'b0;
  logic        intReq;
  logic [5:0]  ackCode;

  int total = 0;
  int failed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  prio_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .devReq(devReq), .maskWe(maskWe),
    .maskData(maskData), .intAck(intAck), .svcEnd(svcEnd),
    .intReq(intReq), .ackCode(ackCode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeMask(input logic [15:0] m);
    @(negedge clk); maskWe = 1'b1; maskData = m;
    @(negedge clk); maskWe = 1'b0; #1;
  endtask

  task automatic ack();
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0; #1;
  endtask

  task automatic endService();
    @(negedge clk); svcEnd = 1'b1;
    @(negedge clk); svcEnd = 1'b0; #1;
  endtask

  task automatic clean();
    devReq = '0;
    writeMask(16'h0000);
    endService();
  endtask

  task automatic testReset();
    #1;
    chk("R1 ackCode after reset", ackCode, 0);
    chk("R1 no interrupt without request", intReq, 0);
    devReq = 16'h0020; #1;
    chk("R1 slot 5 enabled after reset", intReq, 1);
    devReq = 16'h0000; #1;
    chk("R2 interrupt drops with request", intReq, 0);
  endtask

  task automatic testPriority();
    clean();
    devReq = 16'h1088; #1;  // slots 3, 7, 12
    chk("R2 interrupt with several requests", intReq, 1);
    ack();
    chk("R5 lowest slot 3 wins", ackCode, 11);
    chk("R6 interrupt off after ack", intReq, 0);
    devReq = 16'h0001; #1;
    chk("R6 new request stays silent", intReq, 0);
    chk("R10 code holds after request change", ackCode, 11);
    endService();
    chk("R8 end of service rearms", intReq, 1);
  endtask

  task automatic testMask();
    clean();
    writeMask(16'h0008);
    devReq = 16'h0088; #1;
    ack();
    chk("R3 blocked slot 3 skipped", ackCode, 15);
    endService();
    writeMask(16'hFFFF);
    chk("R3 all blocked no interrupt", intReq, 0);
    chk("R10 code holds over mask write", ackCode, 15);
    ack();
    chk("R7 empty ack gives zero", ackCode, 0);
    endService();
  endtask

  task automatic testMaskWord();
    clean();
    writeMask(16'h00FF);
    devReq = 16'h0080; #1;
    chk("R4 slot 7 blocked by low byte", intReq, 0);
    devReq = 16'h0100; #1;
    chk("R4 slot 8 open", intReq, 1);
    writeMask(16'hFF00);
    chk("R4 slot 8 blocked by high byte", intReq, 0);
    devReq = 16'h0080; #1;
    chk("R4 slot 7 open", intReq, 1);
    devReq = 16'h8000; #1;
    chk("R4 slot 15 blocked", intReq, 0);
  endtask

  task automatic testNesting();
    clean();
    devReq = 16'h0200;  // slot 9
    ack();
    chk("R5 slot 9 code", ackCode, 17);
    writeMask(16'hFE00);
    endService();
    chk("R9 own and lower slots silent", intReq, 0);
    devReq = 16'h0204; #1;  // slot 2 arrives
    chk("R9 higher slot breaks in", intReq, 1);
    ack();
    chk("R9 nested code slot 2", ackCode, 10);
    devReq = 16'h0200;
    writeMask(16'h0000);
    endService();
    chk("R9 lower request pending again", intReq, 1);
    ack();
    chk("R9 lower slot resumes", ackCode, 17);
  endtask

  task automatic testCollision();
    clean();
    devReq = 16'h0010;
    @(negedge clk); intAck = 1'b1; svcEnd = 1'b1;
    @(negedge clk); intAck = 1'b0; svcEnd = 1'b0; #1;
    chk("R8 ack beats end of service", intReq, 0);
    chk("R5 slot 4 code", ackCode, 12);
    endService();
    chk("R8 rearm afterwards", intReq, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testPriority();
    testMask();
    testMaskWord();
    testNesting();
    testCollision();
    finished = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule